// File: doc/BRIEF.md
# Page Translation Buffer

This block is a small fully associative cache of page mappings for a 32-bit address space with 4 KB pages. A requester presents a virtual address and a write flag. One clock later the block returns one of three outcomes. On a hit it gives the physical address: the 12-bit offset passes through untouched and the stored frame number replaces the upper 20 bits. A miss means no stored mapping covers the page. A fault means the mapping exists but marks the page as not resident in memory.

Each slot holds a page number, a frame number, a residency flag, a modified flag and a recently-used flag. The block updates the modified and recently-used flags itself whenever an access hits a resident page. The response reports their values as they stood before that access. The slots are loaded by a fill port from whatever walks the page tables. Single mappings are removed with an invalidate port, and a flush input removes all of them in one cycle.

Top module: `addr_xlate_buf`

## Requirements
- R1: On a hit, `rsp_paddr` is the stored 20-bit frame number in bits 31:12 followed by bits 11:0 of the request address, unchanged.
- R2: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high. While it is high, exactly one of `rsp_hit`, `rsp_miss` and `rsp_fault` is high.
- R3: A request whose page number (address bits 31:12) matches no occupied slot gives `rsp_miss`, with `rsp_paddr`, `rsp_dirty` and `rsp_ref` at zero.
- R4: A request that matches a slot loaded with `fill_present` = 0 gives `rsp_fault` and `rsp_paddr` = 0. It leaves the slot's modified and recently-used flags unchanged.
- R5: `rsp_ref` reports the slot's recently-used flag before the access. Every hit sets that flag.
- R6: `rsp_dirty` reports the slot's modified flag before the access. A hit with `req_write` = 1 sets that flag, and a read hit leaves it unchanged.
- R7: A fill for a page number not already held goes to the lowest-numbered unoccupied slot when one exists.
- R8: When all slots are occupied, a fill for a new page number evicts the slot named by a round-robin pointer. The pointer starts at slot 0 and moves on by one, wrapping around, after each such eviction.
- R9: A fill whose page number is already held overwrites that slot. It clears the slot's two flags, creates no duplicate and does not move the round-robin pointer.
- R10: An invalidate removes the slot holding that page number, so later requests to it miss and the slot becomes free for fills.
- R11: A flush empties every slot in one cycle. A fill in the same cycle as a flush is dropped.
- R12: After reset all slots are empty, `rsp_valid` is low and the round-robin pointer is at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request strobe |
| req_write | input | 1 | Request is a store |
| req_vaddr | input | 32 | Virtual address to translate |
| fill_valid | input | 1 | Load a mapping |
| fill_vpn | input | 20 | Page number of the mapping |
| fill_pfn | input | 20 | Frame number of the mapping |
| fill_present | input | 1 | Page is resident in memory |
| inval_valid | input | 1 | Remove one mapping |
| inval_vpn | input | 20 | Page number to remove |
| flush | input | 1 | Remove all mappings |
| rsp_valid | output | 1 | Result strobe, one cycle after the request |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_miss | output | 1 | No mapping held |
| rsp_fault | output | 1 | Mapping held but page not resident |
| rsp_paddr | output | 32 | Physical address, zero unless hit |
| rsp_dirty | output | 1 | Modified flag before this access |
| rsp_ref | output | 1 | Recently-used flag before this access |

## Verification
The bench first fills every slot, including one non-resident page. It then checks that a fault updates neither flag by repeating the access: a design that marked faulting pages as used would report `rsp_ref` high the second time. A refill of an already-held page while the buffer is full must keep every other mapping. A design that duplicated the entry or advanced the pointer would lose slot 0 or slot 1 later. The bench also invalidates one slot and then fills three new pages. The freed slot must be reused first and then slots 0 and 1 evicted in turn, so a victim selector that ignored free slots or started from the wrong place shows the wrong misses. A flush combined with a fill must leave nothing behind.

// File: rtl/addr_xlate_pkg.sv
// Shared geometry of the page translation buffer.
// Assumes a power-of-two page size smaller than the address space.
package addr_xlate_pkg;
    localparam int ADDR_W = 32;
    localparam int OFS_W  = 12;
    localparam int PN_W   = ADDR_W - OFS_W;
    localparam int SLOTS  = 8;
    localparam int SLOT_W = $clog2(SLOTS);
endpackage

// File: rtl/xlate_cam.sv
// Content-addressed compare of one probe key against every live slot key.
// Returns whether any slot matches and the lowest matching index.
// Assumes the caller keeps keys unique among live slots.
module xlate_cam #(
    parameter int N     = 8,
    parameter int KEY_W = 20,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]       live,
    input  logic [N*KEY_W-1:0] keys,
    input  logic [KEY_W-1:0]   probe,
    output logic               found,
    output logic [IDX_W-1:0]   where
);
    logic [N-1:0] eq;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign eq[g] = live[g] && (keys[g*KEY_W +: KEY_W] == probe);
    end

    // Priority encode the match vector, lowest index first.
    always_comb begin
        found = |eq;
        where = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (eq[i]) where = IDX_W'(i);
        end
    end
endmodule

// File: rtl/xlate_victim.sv
// Chooses the slot a fill of a new page lands in: the lowest free slot,
// else the slot under a round-robin pointer that advances on each eviction.
// Assumes 'evict' is raised only in a cycle whose fill used 'pick'.
module xlate_victim #(
    parameter int N     = 8,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     live,
    input  logic             evict,
    output logic [IDX_W-1:0] pick
);
    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] free_idx;
    logic             free_any;

    // Find the lowest unoccupied slot.
    always_comb begin
        free_any = ~&live;
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!live[i]) free_idx = IDX_W'(i);
        end
        pick = free_any ? free_idx : rr_q;
    end

    // Move the round-robin pointer only when a full buffer loses a slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (evict && !free_any) begin
            rr_q <= (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;
        end
    end
endmodule

// File: rtl/addr_xlate_buf.sv
// Fully associative page translation buffer with a registered result.
// Holds SLOTS mappings of page number to frame number with residency,
// modified and recently-used flags; lookups update the flags on hits.
// Assumes at most one of fill/invalidate targets a slot per cycle
// (flush > fill > invalidate > access flag update).
module addr_xlate_buf #(
    parameter int ADDR_W = addr_xlate_pkg::ADDR_W,
    parameter int OFS_W  = addr_xlate_pkg::OFS_W,
    parameter int SLOTS  = addr_xlate_pkg::SLOTS,
    localparam int PN_W   = ADDR_W - OFS_W,
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic              fill_valid,
    input  logic [PN_W-1:0]   fill_vpn,
    input  logic [PN_W-1:0]   fill_pfn,
    input  logic              fill_present,
    input  logic              inval_valid,
    input  logic [PN_W-1:0]   inval_vpn,
    input  logic              flush,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic              rsp_fault,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic              rsp_dirty,
    output logic              rsp_ref
);
    typedef struct packed {
        logic            occ;
        logic            present;
        logic            dirty;
        logic            refd;
        logic [PN_W-1:0] vpn;
        logic [PN_W-1:0] pfn;
    } slot_t;

    slot_t               tab [SLOTS];
    logic [SLOTS-1:0]    occ_vec;
    logic [SLOTS*PN_W-1:0] key_flat;

    for (genvar g = 0; g < SLOTS; g++) begin : g_flat
        assign occ_vec[g]                = tab[g].occ;
        assign key_flat[g*PN_W +: PN_W]  = tab[g].vpn;
    end

    logic              look_hit, fill_hit, inv_hit;
    logic [SLOT_W-1:0] look_idx, fill_idx, inv_idx, victim;
    logic [SLOT_W-1:0] fill_slot;
    logic              fill_go, evict;

    xlate_cam #(.N(SLOTS), .KEY_W(PN_W), .IDX_W(SLOT_W)) u_cam_look (
        .live(occ_vec), .keys(key_flat), .probe(req_vaddr[ADDR_W-1:OFS_W]),
        .found(look_hit), .where(look_idx)
    );
    xlate_cam #(.N(SLOTS), .KEY_W(PN_W), .IDX_W(SLOT_W)) u_cam_fill (
        .live(occ_vec), .keys(key_flat), .probe(fill_vpn),
        .found(fill_hit), .where(fill_idx)
    );
    xlate_cam #(.N(SLOTS), .KEY_W(PN_W), .IDX_W(SLOT_W)) u_cam_inval (
        .live(occ_vec), .keys(key_flat), .probe(inval_vpn),
        .found(inv_hit), .where(inv_idx)
    );

    assign fill_go   = fill_valid && !flush;
    assign evict     = fill_go && !fill_hit;
    assign fill_slot = fill_hit ? fill_idx : victim;

    xlate_victim #(.N(SLOTS), .IDX_W(SLOT_W)) u_victim (
        .clk(clk), .rst_n(rst_n), .live(occ_vec), .evict(evict), .pick(victim)
    );

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        // Maintain one slot: flush, load, remove, or flag update on a hit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tab[g] <= '0;
            end else if (flush) begin
                tab[g].occ <= 1'b0;
            end else if (fill_go && fill_slot == SLOT_W'(g)) begin
                tab[g].occ     <= 1'b1;
                tab[g].present <= fill_present;
                tab[g].dirty   <= 1'b0;
                tab[g].refd    <= 1'b0;
                tab[g].vpn     <= fill_vpn;
                tab[g].pfn     <= fill_pfn;
            end else if (inval_valid && inv_hit && inv_idx == SLOT_W'(g)) begin
                tab[g].occ <= 1'b0;
            end else if (req_valid && look_hit && look_idx == SLOT_W'(g)
                         && tab[g].present) begin
                tab[g].refd <= 1'b1;
                if (req_write) tab[g].dirty <= 1'b1;
            end
        end
    end

    slot_t sel;
    assign sel = tab[look_idx];

    // Register the outcome of this cycle's lookup.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_miss  <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_paddr <= '0;
            rsp_dirty <= 1'b0;
            rsp_ref   <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_hit   <= req_valid && look_hit && sel.present;
            rsp_fault <= req_valid && look_hit && !sel.present;
            rsp_miss  <= req_valid && !look_hit;
            rsp_paddr <= (req_valid && look_hit && sel.present)
                         ? {sel.pfn, req_vaddr[OFS_W-1:0]} : '0;
            rsp_dirty <= req_valid && look_hit && sel.dirty;
            rsp_ref   <= req_valid && look_hit && sel.refd;
        end
    end
endmodule

// File: rtl/xlate_chk.sv
// Protocol checks on the translation buffer ports, bound into every instance.
// Assumes synchronous active-low reset.
module xlate_chk #(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_vaddr,
    input logic              flush,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic              rsp_miss,
    input logic              rsp_fault,
    input logic [ADDR_W-1:0] rsp_paddr
);
    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R2
    AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R2
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_fault}) == 1); // R2
    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (!rsp_hit || rsp_paddr[OFS_W-1:0] == $past(req_vaddr[OFS_W-1:0]))); // R1
    AST_NOHIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> rsp_paddr == '0); // R3
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush ##1 req_valid |=> rsp_miss); // R11
endmodule

bind addr_xlate_buf xlate_chk #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .flush(flush), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr)
);

// File: tb/addr_xlate_buf_bench.sv
// Scoreboard bench: driver tasks queue expected results, a monitor compares.
module addr_xlate_buf_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        fill_valid = 1'b0, fill_present = 1'b0;
    logic [19:0] fill_vpn = '0, fill_pfn = '0;
    logic        inval_valid = 1'b0;
    logic [19:0] inval_vpn = '0;
    logic        flush = 1'b0;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_dirty, rsp_ref;
    logic [31:0] rsp_paddr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [36:0] exp_q [$];
    string       tag_q [$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    addr_xlate_buf u_addr_xlate_buf (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_vaddr(req_vaddr), .fill_valid(fill_valid), .fill_vpn(fill_vpn),
        .fill_pfn(fill_pfn), .fill_present(fill_present), .inval_valid(inval_valid),
        .inval_vpn(inval_vpn), .flush(flush), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_miss(rsp_miss), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
        .rsp_dirty(rsp_dirty), .rsp_ref(rsp_ref)
    );

    // Monitor: pop the oldest expectation whenever a result appears.
    always @(negedge clk) begin
        if (rst_n && rsp_valid && !done) begin
            logic [36:0] act, exp;
            string tag;
            act = {rsp_hit, rsp_miss, rsp_fault, rsp_dirty, rsp_ref, rsp_paddr};
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R2 unexpected result act=%h exp=none", act);
            end else begin
                exp = exp_q.pop_front();
                tag = tag_q.pop_front();
                if (act !== exp) begin
                    fails++;
                    $display("FAIL %s act hmfdr=%b pa=%h exp hmfdr=%b pa=%h",
                             tag, act[36:32], act[31:0], exp[36:32], exp[31:0]);
                end
            end
        end
    end

    task automatic clr();
        req_valid = 0; req_write = 0; fill_valid = 0; inval_valid = 0; flush = 0;
    endtask

    task automatic idle();
        @(negedge clk); clr();
    endtask

    // Outcome codes: 0 miss, 1 hit, 2 fault.
    task automatic access(input logic wr, input logic [19:0] vpn, input logic [11:0] ofs,
                          input int kind, input logic ed, input logic er,
                          input logic [19:0] epfn, input string tag);
        @(negedge clk); clr();
        req_valid = 1; req_write = wr; req_vaddr = {vpn, ofs};
        exp_q.push_back({kind == 1, kind == 0, kind == 2, ed, er,
                         (kind == 1) ? {epfn, ofs} : 32'h0});
        tag_q.push_back(tag);
    endtask

    task automatic fill(input logic [19:0] vpn, input logic [19:0] pfn,
                        input logic pres, input logic fl);
        @(negedge clk); clr();
        fill_valid = 1; fill_vpn = vpn; fill_pfn = pfn; fill_present = pres; flush = fl;
    endtask

    task automatic inval(input logic [19:0] vpn);
        @(negedge clk); clr();
        inval_valid = 1; inval_vpn = vpn;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0) begin
            fails++;
            $display("FAIL R12 rsp_valid act=%b exp=0", rsp_valid);
        end
        access(0, 20'h00010, 12'h000, 0, 0, 0, 0, "R12 empty after reset");

        for (int i = 0; i < 8; i++)
            fill(20'h00100 + 20'(i), 20'h00500 + 20'(3 * i), i != 6, 0);

        access(0, 20'h00100, 12'habc, 1, 0, 0, 20'h00500, "R1 offset passes, R5 ref clear");
        access(0, 20'h00100, 12'habc, 1, 0, 1, 20'h00500, "R5 ref set by hit");
        access(1, 20'h00100, 12'h010, 1, 0, 1, 20'h00500, "R6 write reports prior dirty");
        access(0, 20'h00100, 12'h020, 1, 1, 1, 20'h00500, "R6 dirty set by write");
        access(0, 20'h00101, 12'hfff, 1, 0, 0, 20'h00503, "R1 second slot");
        access(0, 20'h00101, 12'h000, 1, 0, 1, 20'h00503, "R6 read leaves dirty clear");
        access(1, 20'h00106, 12'h004, 2, 0, 0, 0, "R4 fault on absent page");
        access(0, 20'h00106, 12'h004, 2, 0, 0, 0, "R4 fault left flags clear");
        access(0, 20'h00200, 12'h004, 0, 0, 0, 0, "R3 miss");

        fill(20'h00101, 20'h00777, 1, 0);
        access(0, 20'h00101, 12'h123, 1, 0, 0, 20'h00777, "R9 refill overwrites, flags cleared");
        access(0, 20'h00100, 12'h000, 1, 1, 1, 20'h00500, "R9 refill kept slot 0");

        inval(20'h00103);
        access(0, 20'h00103, 12'h000, 0, 0, 0, 0, "R10 invalidated page misses");
        fill(20'h00300, 20'h00333, 1, 0);
        fill(20'h00301, 20'h00334, 1, 0);
        fill(20'h00302, 20'h00335, 1, 0);
        access(0, 20'h00300, 12'h001, 1, 0, 0, 20'h00333, "R7 freed slot reused");
        access(0, 20'h00301, 12'h002, 1, 0, 0, 20'h00334, "R8 first eviction fill");
        access(0, 20'h00302, 12'h003, 1, 0, 0, 20'h00335, "R8 second eviction fill");
        access(0, 20'h00100, 12'h000, 0, 0, 0, 0, "R8 slot 0 evicted first");
        access(0, 20'h00101, 12'h000, 0, 0, 0, 0, "R8 slot 1 evicted second");
        access(0, 20'h00102, 12'h000, 1, 0, 0, 20'h00506, "R7 slot 2 untouched");
        access(0, 20'h00107, 12'h000, 1, 0, 0, 20'h00515, "R8 slot 7 untouched");

        fill(20'h00400, 20'h00444, 1, 1);
        access(0, 20'h00102, 12'h000, 0, 0, 0, 0, "R11 flush emptied slot");
        access(0, 20'h00300, 12'h000, 0, 0, 0, 0, "R11 flush emptied reused slot");
        access(0, 20'h00400, 12'h000, 0, 0, 0, 0, "R11 fill with flush dropped");
        fill(20'h00401, 20'h00445, 1, 0);
        access(1, 20'h00401, 12'h0ff, 1, 0, 0, 20'h00445, "R7 fill after flush");
        access(0, 20'h00401, 12'h0ff, 1, 1, 1, 20'h00445, "R6 flags after write");

        idle(); idle(); idle();
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R2 pending results act=%0d exp=0", exp_q.size());
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL R2 watchdog act=hung exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule